// File: doc/BRIEF.md
# Receiver Power Mode Controller

This block chooses the power state of a video receiver and turns that state into enables for the receiver's power domains and output groups. It takes four inputs into account: a power-down bit written by software, an external power-down pin, an auto power-down enable, and a synchronous activity level from the sync detectors. From these it selects one of three modes: full power, auto power-down or power-down.

A forced power-down always beats the activity-based one. The pin's active level can be set in a register. The pin can be set to cause either a full shutdown or only a release of the output drivers. Each of the three output groups (video data, S/PDIF, I2S) can also be forced into high impedance on its own. A small register file on a simple write/combinational-read bus holds the controls and reports the current mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The mode has three values: full power = 2'b00, auto power-down = 2'b01 and power-down = 2'b10. It appears on `mode` and in bits [1:0] of the read-only status register at address 2. The value 2'b11 never occurs.
- R2: Control register (address 0) bit 0 set forces power-down on the clock edge after the edge that wrote it, whatever the activity and auto settings are.
- R3: `pd_pin` passes through a two-flop synchronizer. Control bit 1 = 0 makes the pin active high, and 1 makes it active low. With control bit 2 = 0, an active pin forces power-down, and the mode changes on the third clock edge after the pin changes.
- R4: With control bit 2 = 1, an active pin drives every `out_oe` bit to 0 and leaves the mode to be decided by the other inputs.
- R5: With auto register (address 1) bit 0 set, activity low and no forced power-down, the mode becomes auto power-down on the next edge. A forced power-down from the register or the pin wins over auto power-down.
- R6: In auto power-down, the mode returns to full power on the first clock edge at which `activity` is sampled high.
- R7: In full power every `dom_en` bit is 1. In the other two modes only bits 0 (serial bus), 1 (activity detect) and 2 (bandgap) are 1.
- R8: `out_oe[i]` (0 video, 1 S/PDIF, 2 I2S) is 1 only when the mode is full power, control bit 5+i is 0, and no pin high-impedance request is active. It updates on the same edge as the mode.
- R9: After reset every control bit is 0, the mode is full power, all domains are on and all outputs are enabled.
- R10: The control and auto registers read back the bits they implement, and unimplemented bits read 0. Address 3 reads 0. Writes to the status address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pd_pin | input | 1 | External power-down pin (asynchronous) |
| activity | input | 1 | Synchronous activity-present level |
| dom_en | output | 8 | Per-domain power enables |
| out_oe | output | 3 | Output-group drive enables (video, S/PDIF, I2S) |
| mode | output | 2 | Current power mode |

## Verification
The mode decision is driven through a table of register and activity combinations. The table separates the pure auto case, register power-down with and without activity, and each force-high-impedance bit alone and together. Together these tell apart priority errors, mix-ups in the output-group bit order, and gating of the output enables by mode. Directed sequences then move the pin through both polarities and both pin options, counting edges to pin down the synchronizer latency. They also time the one-edge wake-up from auto power-down and the one-edge response to a register write, and probe readback of unimplemented and unmapped bits.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [1:0] {
      PM_FULL = 2'b00,
      PM_AUTO = 2'b01,
      PM_DOWN = 2'b10
   } pm_mode_e;

   // register addresses
   localparam int unsigned ADDR_CTL  = 0;
   localparam int unsigned ADDR_AUTO = 1;
   localparam int unsigned ADDR_STAT = 2;

   // control register field positions
   localparam int unsigned CTL_SWPD    = 0;
   localparam int unsigned CTL_PINLOW  = 1;
   localparam int unsigned CTL_PINHIZ  = 2;
   localparam int unsigned CTL_HIZ_LSB = 5;

   // auto register field positions
   localparam int unsigned AUTO_EN = 0;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pmc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
   import pmc_pkg::*;
#(
   parameter int unsigned AW   = 2,
   parameter int unsigned DW   = 8,
   parameter int unsigned NGRP = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  pm_mode_e        cur_mode,
   output logic            sw_pd,
   output logic            pin_low,
   output logic            pin_hiz,
   output logic            auto_en,
   output logic [NGRP-1:0] force_hiz
);
   localparam int unsigned HIZ_MSB = CTL_HIZ_LSB + NGRP - 1;

   if (DW <= HIZ_MSB) begin : g_bad_dw
      $error("pmc_regs: DW too narrow for the force-hiz field");
   end
   if ((1 << AW) <= ADDR_STAT) begin : g_bad_aw
      $error("pmc_regs: AW too narrow for the register map");
   end

   logic ctl_sel, auto_sel;
   logic unused_wbits;

   assign ctl_sel      = bus_wr && (bus_addr == AW'(ADDR_CTL));
   assign auto_sel     = bus_wr && (bus_addr == AW'(ADDR_AUTO));
   assign unused_wbits = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_pd     <= 1'b0;
         pin_low   <= 1'b0;
         pin_hiz   <= 1'b0;
         force_hiz <= '0;
      end else if (ctl_sel) begin
         sw_pd     <= bus_wdata[CTL_SWPD];
         pin_low   <= bus_wdata[CTL_PINLOW];
         pin_hiz   <= bus_wdata[CTL_PINHIZ];
         force_hiz <= bus_wdata[HIZ_MSB:CTL_HIZ_LSB];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        auto_en <= 1'b0;
      else if (auto_sel) auto_en <= bus_wdata[AUTO_EN];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(ADDR_CTL)) begin
         bus_rdata[CTL_SWPD]              = sw_pd;
         bus_rdata[CTL_PINLOW]            = pin_low;
         bus_rdata[CTL_PINHIZ]            = pin_hiz;
         bus_rdata[HIZ_MSB:CTL_HIZ_LSB]   = force_hiz;
      end else if (bus_addr == AW'(ADDR_AUTO)) begin
         bus_rdata[AUTO_EN]               = auto_en;
      end else if (bus_addr == AW'(ADDR_STAT)) begin
         bus_rdata[1:0]                   = cur_mode;
      end
   end

   // R10: register state only moves on a write strobe
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable({sw_pd, pin_low, pin_hiz, force_hiz, auto_en}));
endmodule

// File: rtl/pmc_arbiter.sv
module pmc_arbiter
   import pmc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sw_pd,
   input  logic     pin_lvl,
   input  logic     pin_low,
   input  logic     pin_hiz,
   input  logic     auto_en,
   input  logic     activity,
   output pm_mode_e mode_d,
   output pm_mode_e mode_q,
   output logic     hiz_req
);
   logic pin_on, pin_down, forced;

   assign pin_on   = pin_lvl ^ pin_low;
   assign pin_down = pin_on && !pin_hiz;
   assign hiz_req  = pin_on && pin_hiz;
   assign forced   = sw_pd || pin_down;

   always_comb begin
      if (forced)                     mode_d = PM_DOWN;
      else if (auto_en && !activity)  mode_d = PM_AUTO;
      else                            mode_d = PM_FULL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= PM_FULL;
      else        mode_q <= mode_d;
   end

   a_r1_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != 2'b11);
   a_r2_swpd: assert property (@(posedge clk) disable iff (!rst_n)
      sw_pd |=> mode_q == PM_DOWN);
   a_r3_pin_down: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_on && !pin_hiz) |=> mode_q == PM_DOWN);
   a_r5_auto: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_pd && !pin_down && auto_en && !activity) |=> mode_q == PM_AUTO);
   a_r6_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_pd && !pin_down && activity) |=> mode_q == PM_FULL);
endmodule

// File: rtl/pmc_outputs.sv
module pmc_outputs
   import pmc_pkg::*;
#(
   parameter int unsigned NDOM  = 8,
   parameter int unsigned NKEEP = 3,
   parameter int unsigned NGRP  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  pm_mode_e        mode_d,
   input  pm_mode_e        mode_q,
   input  logic            hiz_req,
   input  logic [NGRP-1:0] force_hiz,
   output logic [NDOM-1:0] dom_en,
   output logic [NGRP-1:0] out_oe
);
   if (NKEEP == 0 || NKEEP >= NDOM) begin : g_bad_keep
      $error("pmc_outputs: NKEEP must be in 1..NDOM-1");
   end

   logic full_q;
   assign full_q = (mode_q == PM_FULL);

   for (genvar i = 0; i < NDOM; i++) begin : g_dom
      if (i < NKEEP) begin : g_keep
         assign dom_en[i] = 1'b1;
      end else begin : g_gated
         assign dom_en[i] = full_q;
      end
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_oe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_oe[g] <= 1'b1;
         else        out_oe[g] <= (mode_d == PM_FULL) && !force_hiz[g] && !hiz_req;
      end
   end

   a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != PM_FULL) |-> (out_oe == '0));
   a_r7_full_dom: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> (&dom_en));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int unsigned AW      = 2,
   parameter int unsigned DW      = 8,
   parameter int unsigned NGRP    = 3,
   parameter int unsigned NDOM    = 8,
   parameter int unsigned NKEEP   = 3,
   parameter int unsigned SYNC_FF = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  logic            pd_pin,
   input  logic            activity,
   output logic [NDOM-1:0] dom_en,
   output logic [NGRP-1:0] out_oe,
   output logic [1:0]      mode
);
   logic            sw_pd, pin_low, pin_hiz, auto_en, pin_lvl, hiz_req;
   logic [NGRP-1:0] force_hiz;
   pm_mode_e        mode_d, mode_q;

   pmc_sync #(.STAGES(SYNC_FF)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pd_pin), .q(pin_lvl));

   pmc_regs #(.AW(AW), .DW(DW), .NGRP(NGRP)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cur_mode(mode_q),
      .sw_pd(sw_pd), .pin_low(pin_low), .pin_hiz(pin_hiz),
      .auto_en(auto_en), .force_hiz(force_hiz));

   pmc_arbiter u_arb (
      .clk(clk), .rst_n(rst_n), .sw_pd(sw_pd), .pin_lvl(pin_lvl),
      .pin_low(pin_low), .pin_hiz(pin_hiz), .auto_en(auto_en),
      .activity(activity), .mode_d(mode_d), .mode_q(mode_q),
      .hiz_req(hiz_req));

   pmc_outputs #(.NDOM(NDOM), .NKEEP(NKEEP), .NGRP(NGRP)) u_out (
      .clk(clk), .rst_n(rst_n), .mode_d(mode_d), .mode_q(mode_q),
      .hiz_req(hiz_req), .force_hiz(force_hiz), .dom_en(dom_en),
      .out_oe(out_oe));

   assign mode = mode_q;

   // R4: a pin hiz request blocks all output drivers on the next edge
   a_r4_pin_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      hiz_req |=> (out_oe == '0));
endmodule

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       pd_pin = 1'b0;
   logic       activity = 1'b1;
   logic [7:0] dom_en;
   logic [2:0] out_oe;
   logic [1:0] mode;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwr_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_pin(pd_pin),
      .activity(activity), .dom_en(dom_en), .out_oe(out_oe), .mode(mode));

   typedef struct packed {
      logic [7:0] ctl;
      logic [7:0] aut;
      logic       act;
      logic [1:0] emode;
      logic [2:0] eoe;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{8'h00, 8'h00, 1'b0, 2'b00, 3'b111},
      '{8'h00, 8'h01, 1'b0, 2'b01, 3'b000},
      '{8'h00, 8'h01, 1'b1, 2'b00, 3'b111},
      '{8'h01, 8'h01, 1'b0, 2'b10, 3'b000},
      '{8'h01, 8'h00, 1'b1, 2'b10, 3'b000},
      '{8'h20, 8'h00, 1'b1, 2'b00, 3'b110},
      '{8'h40, 8'h01, 1'b1, 2'b00, 3'b101},
      '{8'h80, 8'h00, 1'b0, 2'b00, 3'b011},
      '{8'hE0, 8'h01, 1'b1, 2'b00, 3'b000},
      '{8'hA0, 8'h01, 1'b0, 2'b01, 3'b000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      settle(3);
      rst_n = 1'b1;
      // R9 reset state
      @(negedge clk);
      check("R9 mode", mode, 2'b00);
      check("R9 oe", out_oe, 3'b111);
      check("R9 dom", dom_en, 8'hFF);
      rd(2'd0, r); check("R9 ctl", r, 8'h00);
      rd(2'd1, r); check("R9 auto", r, 8'h00);
      rd(2'd2, r); check("R1 status at reset", r, 8'h00);

      // table of mode decisions: R2 R5 R6 R8
      for (int i = 0; i < NV; i++) begin
         activity = VEC[i].act;
         wr(2'd0, VEC[i].ctl);
         wr(2'd1, VEC[i].aut);
         settle(2);
         check($sformatf("R5/R2 vec%0d mode", i), mode, VEC[i].emode);
         check($sformatf("R8 vec%0d oe", i), out_oe, VEC[i].eoe);
         rd(2'd2, r);
         check($sformatf("R1 vec%0d status", i), r, {6'd0, VEC[i].emode});
      end

      wr(2'd0, 8'h00); wr(2'd1, 8'h00); activity = 1'b1; settle(2);

      // R2 latency: one edge after the write edge
      wr(2'd0, 8'h01);
      check("R2 not yet", mode, 2'b00);
      @(negedge clk);
      check("R2 down", mode, 2'b10);
      check("R7 dom in down", dom_en, 8'h07);
      check("R8 oe in down", out_oe, 3'b000);
      wr(2'd0, 8'h00); settle(2);

      // R6 wake on first active clock
      wr(2'd1, 8'h01); activity = 1'b0; settle(2);
      check("R5 auto", mode, 2'b01);
      check("R7 dom in auto", dom_en, 8'h07);
      activity = 1'b1;
      @(negedge clk);
      check("R6 wake", mode, 2'b00);
      check("R7 dom full", dom_en, 8'hFF);
      check("R8 oe wake", out_oe, 3'b111);

      // R5 forced wins over auto
      activity = 1'b0;
      wr(2'd0, 8'h01); settle(2);
      check("R5 forced beats auto", mode, 2'b10);
      wr(2'd0, 8'h00); wr(2'd1, 8'h00); activity = 1'b1; settle(2);

      // R3 pin latency, active high
      @(negedge clk); pd_pin = 1'b1;
      @(negedge clk); check("R3 edge1", mode, 2'b00);
      @(negedge clk); check("R3 edge2", mode, 2'b00);
      @(negedge clk); check("R3 edge3", mode, 2'b10);
      pd_pin = 1'b0; settle(4);
      check("R3 release", mode, 2'b00);
      // R3 active low
      wr(2'd0, 8'h02); settle(2);
      check("R3 low-active down", mode, 2'b10);
      pd_pin = 1'b1; settle(4);
      check("R3 low-active idle", mode, 2'b00);
      pd_pin = 1'b0;
      wr(2'd0, 8'h00); settle(4);

      // R4 pin hiz-only option
      wr(2'd0, 8'h04); pd_pin = 1'b1; settle(4);
      check("R4 mode full", mode, 2'b00);
      check("R4 oe off", out_oe, 3'b000);
      check("R4 dom on", dom_en, 8'hFF);
      wr(2'd1, 8'h01); activity = 1'b0; settle(2);
      check("R4 mode by others", mode, 2'b01);
      pd_pin = 1'b0; activity = 1'b1; settle(4);
      check("R4 release mode", mode, 2'b00);
      check("R4 release oe", out_oe, 3'b111);
      wr(2'd1, 8'h00);

      // R10 readback
      wr(2'd0, 8'hFF); rd(2'd0, r); check("R10 ctl readback", r, 8'hE7);
      wr(2'd1, 8'hFF); rd(2'd1, r); check("R10 auto readback", r, 8'h01);
      rd(2'd3, r); check("R10 unmapped", r, 8'h00);
      wr(2'd0, 8'h00); wr(2'd1, 8'h00); settle(2);
      wr(2'd2, 8'hFF); settle(2);
      check("R10 status write ignored", mode, 2'b00);
      rd(2'd2, r); check("R10 status read", r, 8'h00);
      rd(2'd0, r); check("R10 ctl untouched", r, 8'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule